// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block watches the first bytes of every received HDLC frame and decides whether the frame is kept. It takes a stream of de-stuffed bytes. A start strobe marks the opening flag. A valid strobe qualifies each byte, and an end strobe closes the frame. Flag hunting, bit de-stuffing, CRC and buffering are done elsewhere.

Four modes are selected by `mode_i`:
- **00, single-byte address.** The address is compared with a command and a response address.
- **01, two-byte address.** A high byte must match either of two high addresses, and a low byte must match the command address.
- **10, high-byte recognition.** Only the high byte is filtered, and the following byte is captured.
- **11, raw.** Nothing is filtered, and the first byte is captured.

In auto mode, with address recognition active, the one or two control bytes that follow the address are collected and presented together. All remaining bytes of an accepted frame go out as data.

The low-address register is one storage location with two roles. In the recognition modes it is the command address that software writes. In the transparent modes it is the capture register that software reads, and writes to it are refused.

Top module: `hdlc_addr_filter`

## Requirements
- R1: In mode 01, the frame is accepted only if byte 0 equals `hi0_i` or `hi1_i` and byte 1 equals the low-address register. `cmd_o` stays 0.
- R2: In mode 00, byte 0 is compared against two addresses:
  - equal to the low-address register: accept with `cmd_o`=1 (command);
  - else equal to `lo_rsp_i`: accept with `cmd_o`=0 (response);
  - otherwise: reject.
- R3: In mode 10, the frame is accepted only if byte 0 equals `hi0_i` or `hi1_i`. On acceptance, byte 1 is loaded into the low-address register and appears on `lo_o`.
- R4: In mode 11, every frame is accepted after one address byte, and byte 0 is loaded into the low-address register.
- R5: The control field is parsed only when `auto_i`=1 and `mode_i[1]`=0. It has one byte when `mod128_i`=0 and two bytes when `mod128_i`=1. `ctrl_vld_o` pulses for one cycle after the last control byte. `ctrl_o[7:0]` holds the first control byte, and `ctrl_o[15:8]` holds the second byte (0 in the one-byte case).
- R6: `lo_we_i` loads `lo_wdata_i` into the low-address register only while `mode_i[1]`=0. In modes 10 and 11 the write has no effect on `lo_o`.
- R7: `decided_o`, `accept_o` and `cmd_o` are updated in the cycle after the last address byte. They hold until end-of-frame, and are cleared by `eof_i` or `sof_i`.
- R8: At `eof_i`, `end_ok_o` pulses if the frame was decided and accepted; otherwise `end_drop_o` pulses. A frame that ends before its address is complete is therefore dropped.
- R9: Bytes after the header of an accepted frame appear on `data_o` with a one-cycle `data_vld_o`. This includes bytes after the address when control parsing is off. A rejected frame produces no data strobes.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| mode_i | input | 2 | 00 one-byte, 01 two-byte, 10 high-byte only, 11 raw |
| auto_i | input | 1 | enable control-field parsing |
| mod128_i | input | 1 | 0: one control byte, 1: two |
| hi0_i | input | DW | first high address |
| hi1_i | input | DW | second high address |
| lo_rsp_i | input | DW | response address for mode 00 |
| lo_we_i | input | 1 | low-address register write strobe |
| lo_wdata_i | input | DW | low-address register write data |
| sof_i | input | 1 | frame start strobe |
| byte_vld_i | input | 1 | byte valid |
| byte_i | input | DW | received byte |
| eof_i | input | 1 | frame end strobe |
| decided_o | output | 1 | address decision made |
| accept_o | output | 1 | frame accepted |
| cmd_o | output | 1 | command frame (mode 00) |
| lo_o | output | DW | low-address register contents |
| ctrl_vld_o | output | 1 | control field complete |
| ctrl_o | output | 2*DW | control field bytes |
| data_vld_o | output | 1 | data byte strobe |
| data_o | output | DW | data byte |
| end_ok_o | output | 1 | accepted frame ended |
| end_drop_o | output | 1 | frame discarded at end |

## Verification
The bench builds the block with the default byte width DW=8. At that width, distinct byte patterns can hit each of the two high addresses separately, and can miss by a single bit in either address byte. The two control bytes have distinct values, so the layout of `ctrl_o` can be checked. The capture register is given values that can be told apart from the written command address, so a refused write or a missed capture shows up on `lo_o`.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam logic [1:0] MODE_ADDR8  = 2'b00;
  localparam logic [1:0] MODE_ADDR16 = 2'b01;
  localparam logic [1:0] MODE_HI     = 2'b10;
  localparam logic [1:0] MODE_RAW    = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CTRL, ST_DATA, ST_SKIP
  } af_state_e;
endpackage

// File: rtl/hdlc_af_match.sv
module hdlc_af_match
  import hdlc_af_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NUM_HI = 2
) (
  input  logic [1:0]              mode_i,
  input  logic [1:0]              idx_i,
  input  logic [DW-1:0]           byte_i,
  input  logic [NUM_HI-1:0][DW-1:0] hi_i,
  input  logic [DW-1:0]           lo_cmd_i,
  input  logic [DW-1:0]           lo_rsp_i,
  output logic                    pass_o,
  output logic                    cmd_hit_o,
  output logic                    cap_o
);
  logic [NUM_HI-1:0] hi_eq;
  for (genvar g = 0; g < NUM_HI; g++) begin : g_hi
    assign hi_eq[g] = (byte_i == hi_i[g]);
  end

  logic hi_hit, cmd_eq, rsp_eq;
  assign hi_hit = |hi_eq;
  assign cmd_eq = (byte_i == lo_cmd_i);
  assign rsp_eq = (byte_i == lo_rsp_i);

  always_comb begin
    pass_o    = 1'b1;
    cmd_hit_o = 1'b0;
    cap_o     = 1'b0;
    unique case (mode_i)
      MODE_ADDR8: begin
        pass_o    = cmd_eq | rsp_eq;
        cmd_hit_o = cmd_eq;
      end
      MODE_ADDR16: pass_o = (idx_i == 2'd0) ? hi_hit : cmd_eq;
      MODE_HI: begin
        pass_o = (idx_i == 2'd0) ? hi_hit : 1'b1;
        cap_o  = (idx_i == 2'd1);
      end
      default: cap_o = (idx_i == 2'd0);
    endcase
  end
endmodule

// File: rtl/hdlc_af_seq.sv
module hdlc_af_seq
  import hdlc_af_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sof_i,
  input  logic       byte_vld_i,
  input  logic       eof_i,
  input  logic [1:0] addr_len_i,
  input  logic [1:0] ctrl_len_i,
  input  logic       pass_i,
  input  logic       cmd_hit_i,
  output logic       addr_stb_o,
  output logic       ctrl_stb_o,
  output logic       data_stb_o,
  output logic [1:0] idx_o,
  output logic       ctrl_last_o,
  output logic       ok_o,
  output logic       decided_o,
  output logic       accept_o,
  output logic       cmd_o,
  output logic       end_ok_o,
  output logic       end_drop_o
);
  af_state_e  st_q;
  logic [1:0] cnt_q;
  logic       ok_q, dec_q, acc_q, cmd_q, eok_q, edrop_q;
  logic       byte_go, addr_last;

  assign byte_go     = byte_vld_i & ~sof_i & ~eof_i;
  assign addr_stb_o  = byte_go & (st_q == ST_ADDR);
  assign ctrl_stb_o  = byte_go & (st_q == ST_CTRL);
  assign data_stb_o  = byte_go & (st_q == ST_DATA);
  assign addr_last   = (cnt_q == addr_len_i - 2'd1);
  assign ctrl_last_o = (cnt_q == ctrl_len_i - 2'd1);
  assign idx_o       = cnt_q;
  assign ok_o        = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; ok_q <= 1'b0;
      dec_q <= 1'b0; acc_q <= 1'b0; cmd_q <= 1'b0;
      eok_q <= 1'b0; edrop_q <= 1'b0;
    end else begin
      eok_q   <= 1'b0;
      edrop_q <= 1'b0;
      if (sof_i) begin
        st_q <= ST_ADDR; cnt_q <= '0; ok_q <= 1'b1;
        dec_q <= 1'b0; acc_q <= 1'b0; cmd_q <= 1'b0;
      end else if (eof_i) begin
        if (st_q != ST_IDLE) begin
          eok_q   <= dec_q & acc_q;
          edrop_q <= ~(dec_q & acc_q);
        end
        st_q <= ST_IDLE; dec_q <= 1'b0; acc_q <= 1'b0; cmd_q <= 1'b0;
      end else if (addr_stb_o) begin
        if (addr_last) begin
          dec_q <= 1'b1;
          acc_q <= ok_q & pass_i;
          cmd_q <= ok_q & pass_i & cmd_hit_i;
          cnt_q <= '0;
          if (!(ok_q & pass_i))     st_q <= ST_SKIP;
          else if (ctrl_len_i != 0) st_q <= ST_CTRL;
          else                      st_q <= ST_DATA;
        end else begin
          ok_q  <= ok_q & pass_i;
          cnt_q <= cnt_q + 2'd1;
        end
      end else if (ctrl_stb_o) begin
        cnt_q <= cnt_q + 2'd1;
        if (ctrl_last_o) st_q <= ST_DATA;
      end
    end
  end

  assign decided_o  = dec_q;
  assign accept_o   = acc_q;
  assign cmd_o      = cmd_q;
  assign end_ok_o   = eok_q;
  assign end_drop_o = edrop_q;
endmodule

// File: rtl/hdlc_af_ctrl.sv
module hdlc_af_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [1:0]    idx_i,
  input  logic          last_i,
  input  logic [DW-1:0] byte_i,
  output logic          vld_o,
  output logic [2*DW-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= stb_i & last_i;
      if (stb_i) begin
        if (idx_i == 2'd0) ctrl_o <= {{DW{1'b0}}, byte_i};
        else               ctrl_o[DW +: DW] <= byte_i;
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          auto_i,
  input  logic          mod128_i,
  input  logic [DW-1:0] hi0_i,
  input  logic [DW-1:0] hi1_i,
  input  logic [DW-1:0] lo_rsp_i,
  input  logic          lo_we_i,
  input  logic [DW-1:0] lo_wdata_i,
  input  logic          sof_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          eof_i,
  output logic          decided_o,
  output logic          accept_o,
  output logic          cmd_o,
  output logic [DW-1:0] lo_o,
  output logic          ctrl_vld_o,
  output logic [2*DW-1:0] ctrl_o,
  output logic          data_vld_o,
  output logic [DW-1:0] data_o,
  output logic          end_ok_o,
  output logic          end_drop_o
);
  localparam int NUM_HI = 2;

  logic       transp;
  logic [1:0] addr_len, ctrl_len, idx;
  logic       pass, cmd_hit, cap_now;
  logic       addr_stb, ctrl_stb, data_stb, ctrl_last, ok;
  logic [DW-1:0] lo_q, data_q;
  logic          dvld_q;

  assign transp   = mode_i[1];
  assign addr_len = (mode_i == MODE_ADDR8 || mode_i == MODE_RAW) ? 2'd1 : 2'd2;
  assign ctrl_len = (auto_i && !transp) ? (mod128_i ? 2'd2 : 2'd1) : 2'd0;

  hdlc_af_match #(.DW(DW), .NUM_HI(NUM_HI)) u_match (
    .mode_i(mode_i), .idx_i(idx), .byte_i(byte_i), .hi_i({hi1_i, hi0_i}),
    .lo_cmd_i(lo_q), .lo_rsp_i(lo_rsp_i),
    .pass_o(pass), .cmd_hit_o(cmd_hit), .cap_o(cap_now)
  );

  hdlc_af_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .byte_vld_i(byte_vld_i),
    .eof_i(eof_i), .addr_len_i(addr_len), .ctrl_len_i(ctrl_len),
    .pass_i(pass), .cmd_hit_i(cmd_hit),
    .addr_stb_o(addr_stb), .ctrl_stb_o(ctrl_stb), .data_stb_o(data_stb),
    .idx_o(idx), .ctrl_last_o(ctrl_last), .ok_o(ok),
    .decided_o(decided_o), .accept_o(accept_o), .cmd_o(cmd_o),
    .end_ok_o(end_ok_o), .end_drop_o(end_drop_o)
  );

  hdlc_af_ctrl #(.DW(DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(ctrl_stb), .idx_i(idx),
    .last_i(ctrl_last), .byte_i(byte_i), .vld_o(ctrl_vld_o), .ctrl_o(ctrl_o)
  );

  // shared register: command address when filtering, capture when transparent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      data_q <= '0;
      dvld_q <= 1'b0;
    end else begin
      if (transp) begin
        if (addr_stb && cap_now && ok && pass) lo_q <= byte_i;
      end else if (lo_we_i) begin
        lo_q <= lo_wdata_i;
      end
      dvld_q <= data_stb;
      if (data_stb) data_q <= byte_i;
    end
  end

  assign lo_o       = lo_q;
  assign data_vld_o = dvld_q;
  assign data_o     = data_q;
endmodule

// File: rtl/hdlc_af_chk.sv
module hdlc_af_chk
  import hdlc_af_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          auto_i,
  input logic          sof_i,
  input logic          eof_i,
  input logic          byte_vld_i,
  input logic          decided_o,
  input logic          accept_o,
  input logic          cmd_o,
  input logic [DW-1:0] lo_o,
  input logic          ctrl_vld_o,
  input logic          data_vld_o,
  input logic          end_ok_o,
  input logic          end_drop_o
);
  p_ctrl_auto_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_vld_o |-> (auto_i && !mode_i[1]));
  p_data_acc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> (decided_o && accept_o));
  p_raw_acc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decided_o && mode_i == MODE_RAW) |-> accept_o);
  p_end_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(end_ok_o && end_drop_o));
  p_cmd_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o |-> (mode_i == MODE_ADDR8));
  p_decided_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(decided_o) |-> $past(eof_i || sof_i));
  p_lo_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && $past(mode_i[1]) && !$stable(lo_o)) |-> $past(byte_vld_i));
endmodule

bind hdlc_addr_filter hdlc_af_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .auto_i(auto_i),
  .sof_i(sof_i), .eof_i(eof_i), .byte_vld_i(byte_vld_i),
  .decided_o(decided_o), .accept_o(accept_o), .cmd_o(cmd_o), .lo_o(lo_o),
  .ctrl_vld_o(ctrl_vld_o), .data_vld_o(data_vld_o),
  .end_ok_o(end_ok_o), .end_drop_o(end_drop_o)
);

// File: tb/hdlc_addr_filter_test.sv
module hdlc_addr_filter_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] mode = 2'b00;
  logic auto_en = 1'b0, m128 = 1'b0;
  logic [DW-1:0] hi0 = 8'h12, hi1 = 8'h34, lo_rsp = 8'h78;
  logic lo_we = 1'b0;
  logic [DW-1:0] lo_wd = '0;
  logic sof = 1'b0, bvld = 1'b0, eof = 1'b0;
  logic [DW-1:0] bdat = '0;
  logic dec, acc, cmd, cvld, dvld, eok, edrop;
  logic [DW-1:0] lo, dout;
  logic [2*DW-1:0] ctrl;

  hdlc_addr_filter #(.DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .auto_i(auto_en),
    .mod128_i(m128), .hi0_i(hi0), .hi1_i(hi1), .lo_rsp_i(lo_rsp),
    .lo_we_i(lo_we), .lo_wdata_i(lo_wd), .sof_i(sof), .byte_vld_i(bvld),
    .byte_i(bdat), .eof_i(eof), .decided_o(dec), .accept_o(acc),
    .cmd_o(cmd), .lo_o(lo), .ctrl_vld_o(cvld), .ctrl_o(ctrl),
    .data_vld_o(dvld), .data_o(dout), .end_ok_o(eok), .end_drop_o(edrop)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof = 1'b1; @(negedge clk); sof = 1'b0;
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk); bvld = 1'b1; bdat = b; @(negedge clk); bvld = 1'b0;
  endtask
  task automatic pulse_eof();
    @(negedge clk); eof = 1'b1; @(negedge clk); eof = 1'b0;
  endtask
  task automatic wr_lo(input logic [7:0] v);
    @(negedge clk); lo_we = 1'b1; lo_wd = v; @(negedge clk); lo_we = 1'b0;
  endtask

  // {mode[1:0], b0[7:0], b1[7:0], 2'b0, acc, cmd}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {2'b00, 8'h56, 8'h00, 2'b0, 1'b1, 1'b1},
    {2'b00, 8'h78, 8'h00, 2'b0, 1'b1, 1'b0},
    {2'b00, 8'h99, 8'h00, 2'b0, 1'b0, 1'b0},
    {2'b01, 8'h12, 8'h56, 2'b0, 1'b1, 1'b0},
    {2'b01, 8'h34, 8'h56, 2'b0, 1'b1, 1'b0},
    {2'b01, 8'h12, 8'h57, 2'b0, 1'b0, 1'b0},
    {2'b01, 8'h13, 8'h56, 2'b0, 1'b0, 1'b0},
    {2'b10, 8'h34, 8'hAB, 2'b0, 1'b1, 1'b0},
    {2'b10, 8'h35, 8'hAC, 2'b0, 1'b0, 1'b0},
    {2'b11, 8'hEE, 8'h00, 2'b0, 1'b1, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] exp_lo;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 decided", {15'b0, dec}, 16'h0);
    chk("R10 accept", {15'b0, acc}, 16'h0);
    chk("R10 outputs", {9'b0, cmd, cvld, dvld, eok, edrop, 2'b0}, 16'h0);
    chk("R10 lo", {8'h0, lo}, 16'h0);
    rst_n = 1'b1;
    exp_lo = 8'h00;

    for (int i = 0; i < NV; i++) begin
      logic [1:0] m; logic [7:0] b0, b1; logic ea, ec;
      {m, b0, b1} = VEC[i][21:4];
      ea = VEC[i][1]; ec = VEC[i][0];
      @(negedge clk); mode = m;
      if (!m[1]) begin wr_lo(8'h56); exp_lo = 8'h56; end
      pulse_sof();
      send(b0);
      if (m == 2'b01 || m == 2'b10) send(b1);
      chk($sformatf("R1/R2/R3/R4 vec%0d decided (R7)", i), {15'b0, dec}, 16'h1);
      chk($sformatf("R1/R2/R3/R4 vec%0d accept", i), {15'b0, acc}, {15'b0, ea});
      chk($sformatf("R2 vec%0d cmd", i), {15'b0, cmd}, {15'b0, ec});
      if (m == 2'b10 && ea) exp_lo = b1;
      if (m == 2'b11) exp_lo = b0;
      chk($sformatf("R3/R4 vec%0d lo", i), {8'h0, lo}, {8'h0, exp_lo});
      pulse_eof();
      chk($sformatf("R8 vec%0d end_ok", i), {14'b0, eok, edrop}, {14'b0, ea, ~ea});
      chk($sformatf("R7 vec%0d cleared", i), {15'b0, dec}, 16'h0);
    end

    // R5 modulo 8 control, then R9 data
    @(negedge clk); mode = 2'b00; auto_en = 1'b1; m128 = 1'b0;
    wr_lo(8'h56);
    pulse_sof(); send(8'h56);
    send(8'h11);
    chk("R5 mod8 ctrl_vld", {15'b0, cvld}, 16'h1);
    chk("R5 mod8 ctrl", ctrl, 16'h0011);
    send(8'hAA);
    chk("R9 data after ctrl", {7'b0, dvld, dout}, {7'b0, 1'b1, 8'hAA});
    chk("R5 ctrl_vld one cycle", {15'b0, cvld}, 16'h0);
    pulse_eof();

    // R5 modulo 128 two-byte control in mode 01
    @(negedge clk); mode = 2'b01; m128 = 1'b1;
    pulse_sof(); send(8'h12); send(8'h56);
    send(8'h21);
    chk("R5 mod128 first byte no vld", {15'b0, cvld}, 16'h0);
    send(8'h43);
    chk("R5 mod128 ctrl_vld", {15'b0, cvld}, 16'h1);
    chk("R5 mod128 ctrl", ctrl, 16'h4321);
    pulse_eof();

    // R5/R9 non-auto: byte after address is data
    @(negedge clk); mode = 2'b00; auto_en = 1'b0;
    pulse_sof(); send(8'h78); send(8'h5A);
    chk("R5 nonauto no ctrl", {15'b0, cvld}, 16'h0);
    chk("R9 nonauto data", {7'b0, dvld, dout}, {7'b0, 1'b1, 8'h5A});
    pulse_eof();

    // R5 transparent with auto set: no control parsing
    @(negedge clk); mode = 2'b11; auto_en = 1'b1;
    pulse_sof(); send(8'hC3); send(8'h3C);
    chk("R5 transparent no ctrl", {15'b0, cvld}, 16'h0);
    chk("R9 transparent data", {7'b0, dvld, dout}, {7'b0, 1'b1, 8'h3C});
    chk("R4 capture", {8'h0, lo}, 16'h00C3);
    pulse_eof();

    // R6 write ignored in transparent mode, honoured in recognition mode
    wr_lo(8'h99);
    chk("R6 write ignored mode11", {8'h0, lo}, 16'h00C3);
    @(negedge clk); mode = 2'b10;
    wr_lo(8'h98);
    chk("R6 write ignored mode10", {8'h0, lo}, 16'h00C3);
    @(negedge clk); mode = 2'b01; auto_en = 1'b0;
    wr_lo(8'h66);
    chk("R6 write taken mode01", {8'h0, lo}, 16'h0066);

    // R8 short frame in two-byte mode
    pulse_sof(); send(8'h12);
    chk("R7 not decided mid-address", {15'b0, dec}, 16'h0);
    pulse_eof();
    chk("R8 short frame drop", {14'b0, eok, edrop}, 16'h0001);

    // R9 rejected frame: no data
    pulse_sof(); send(8'h12); send(8'h67); send(8'h44);
    chk("R9 rejected no data", {15'b0, dvld}, 16'h0);
    chk("R1 rejected accept", {15'b0, acc}, 16'h0);
    pulse_eof();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule